// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses for a pointer that walks a buffer held between two programmable bounds. A pointer register advances by a signed step on each update strobe. In circular mode, a result that leaves the window is folded back inside. The fold adds or subtracts the window length once.

The two bounds may be loaded in either order. Whichever bound is smaller is the low edge of the window. The length is the difference of the bounds plus one. Two further modes are available:
- **Linear:** plain modular addition of the step.
- **Bit-reversed:** the step is added with the carry running from the top bit down to bit 0, which walks FFT data in bit-reversed order.

The current pointer and the address the next update would commit are both visible at the outputs. Software loads the bounds and the pointer through three write strobes that share one data bus.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset the pointer and both bound registers are zero, so `cur_addr` reads 0.
- R2: `wr_ptr` loads `wr_data` into the pointer at the next clock edge. When `wr_ptr` and `upd` are asserted in the same cycle, `wr_ptr` wins.
- R3: Writing either bound (`wr_lo_bound`, `wr_hi_bound`) never moves the pointer.
- R4: In mode 2'b00 (linear), an update makes the pointer `cur_addr + step` modulo 2^AW. For example, 0x0400 with step 0x0040 gives 0x0440, and 0x0400 with step 1 gives 0x0401.
- R5: In mode 2'b01 (circular), the window is lo..hi, where lo and hi are the smaller and larger of the two bounds, and its length is hi-lo+1. A sum above hi has the length subtracted. With bounds 0x0200 and 0x020F, an update that reaches 0x0212 gives 0x0202.
- R6: In circular mode, a sum below lo has the length added. With bounds 0x0200 and 0x020F, an update that reaches 0x01FC gives 0x020C.
- R7: When the first bound register holds the larger value, the window and length follow R5 and R6 in the same way. With bounds 0x030F and 0x0300, the sum 0x0312 gives 0x0302.
- R8: In mode 2'b10 (bit-reversed), the step is added to the pointer with the carry propagating from bit AW-1 toward bit 0. Any carry out of bit 0 is dropped. With step 0x0008, the pointer visits 0x0, 0x8, 0x4, 0xC, 0x2, and so on.
- R9: In mode 2'b11, or whenever `upd` is low, the pointer holds its value.
- R10: `nxt_addr` shows, without delay, the value that an update in the current cycle would commit.
- R11: A step whose magnitude exceeds the window length is folded once only. With window 0x0200..0x020F, pointer 0x020F and step 0x0025, the result is 0x0224.
- R12: `step` is two's complement. In linear mode, step 0xFFFF from 0x0000 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo_bound | input | 1 | Load first bound register from wr_data |
| wr_hi_bound | input | 1 | Load second bound register from wr_data |
| wr_ptr | input | 1 | Load pointer from wr_data |
| wr_data | input | AW | Shared write data |
| step | input | AW | Signed step for the update |
| mode | input | 2 | 00 linear, 01 circular, 10 bit-reversed, 11 hold |
| upd | input | 1 | Commit nxt_addr into the pointer |
| cur_addr | output | AW | Current pointer |
| nxt_addr | output | AW | Address the next update would produce |

## Verification
Circular updates are tried with the sum landing inside the window, past the upper edge, and under the lower edge. These three cases separate the no-fold path from each fold direction.

The same crossings are repeated with the bounds loaded in reversed order. This shows whether the block orders the bounds itself or trusts the register order.

An oversized step separates a single fold from a true modulo.

A run of bit-reversed updates followed through all sixteen indices exposes any carry running in the wrong direction.

Linear steps with a negative value check the sign extension of `step`.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    CAG_LINEAR = 2'b00,
    CAG_CIRC   = 2'b01,
    CAG_BITREV = 2'b10,
    CAG_HOLD   = 2'b11
  } cag_mode_e;
endpackage

// File: rtl/cag_window.sv
// Orders the two bounds and derives the window length (modulo 2^AW).
module cag_window #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] bound_a,
  input  logic [AW-1:0] bound_b,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi,
  output logic [AW-1:0] len
);
  logic a_is_low;

  assign a_is_low = (bound_a <= bound_b);
  assign lo       = a_is_low ? bound_a : bound_b;
  assign hi       = a_is_low ? bound_b : bound_a;
  assign len      = hi - lo + {{(AW-1){1'b0}}, 1'b1};
endmodule

// File: rtl/cag_fold.sv
// Adds a signed step and folds the result back into lo..hi once.
module cag_fold #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          over_hi,
  output logic          under_lo
);
  localparam int EW = AW + 2;

  function automatic logic signed [EW-1:0] wide_sum(input logic [AW-1:0] p,
                                                    input logic [AW-1:0] s);
    logic signed [EW-1:0] pe;
    logic signed [EW-1:0] se;
    pe = $signed({2'b00, p});
    se = $signed({{2{s[AW-1]}}, s});
    return pe + se;
  endfunction

  logic signed [EW-1:0] sum_w;
  logic signed [EW-1:0] lo_w;
  logic signed [EW-1:0] hi_w;
  logic [AW-1:0]        raw;

  assign sum_w    = wide_sum(ptr, step);
  assign lo_w     = $signed({2'b00, lo});
  assign hi_w     = $signed({2'b00, hi});
  assign over_hi  = (sum_w > hi_w);
  assign under_lo = (sum_w < lo_w);
  assign raw      = ptr + step;

  always_comb begin
    if (over_hi)       addr = raw - len;
    else if (under_lo) addr = raw + len;
    else               addr = raw;
  end
endmodule

// File: rtl/cag_revadd.sv
// Addition with the carry running from the top bit toward bit 0.
module cag_revadd #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] ptr_r;
  logic [AW-1:0] step_r;
  logic [AW-1:0] sum_r;

  for (genvar i = 0; i < AW; i++) begin : g_flip_in
    assign ptr_r[i]  = ptr[AW-1-i];
    assign step_r[i] = step[AW-1-i];
  end

  assign sum_r = ptr_r + step_r;

  for (genvar i = 0; i < AW; i++) begin : g_flip_out
    assign addr[i] = sum_r[AW-1-i];
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo_bound,
  input  logic          wr_hi_bound,
  input  logic          wr_ptr,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] step,
  input  logic [1:0]    mode,
  input  logic          upd,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] bound_a_q;
  logic [AW-1:0] bound_b_q;
  logic [AW-1:0] ptr_q;

  // Named internal events, visible to the bound checker.
  logic [AW-1:0] win_lo;
  logic [AW-1:0] win_hi;
  logic [AW-1:0] win_len;
  logic [AW-1:0] circ_addr;
  logic [AW-1:0] rev_addr;
  logic [AW-1:0] lin_addr;
  logic          fold_hi;
  logic          fold_lo;
  cag_mode_e     mode_e;

  assign mode_e = cag_mode_e'(mode);

  cag_window #(.AW(AW)) u_window (
    .bound_a (bound_a_q),
    .bound_b (bound_b_q),
    .lo      (win_lo),
    .hi      (win_hi),
    .len     (win_len)
  );

  cag_fold #(.AW(AW)) u_fold (
    .ptr      (ptr_q),
    .step     (step),
    .lo       (win_lo),
    .hi       (win_hi),
    .len      (win_len),
    .addr     (circ_addr),
    .over_hi  (fold_hi),
    .under_lo (fold_lo)
  );

  cag_revadd #(.AW(AW)) u_revadd (
    .ptr  (ptr_q),
    .step (step),
    .addr (rev_addr)
  );

  assign lin_addr = ptr_q + step;

  always_comb begin
    unique case (mode_e)
      CAG_LINEAR: nxt_addr = lin_addr;
      CAG_CIRC:   nxt_addr = circ_addr;
      CAG_BITREV: nxt_addr = rev_addr;
      default:    nxt_addr = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_a_q <= '0;
      bound_b_q <= '0;
      ptr_q     <= '0;
    end else begin
      if (wr_lo_bound) bound_a_q <= wr_data;
      if (wr_hi_bound) bound_b_q <= wr_data;
      if (wr_ptr)      ptr_q     <= wr_data;
      else if (upd)    ptr_q     <= nxt_addr;
    end
  end

  assign cur_addr = ptr_q;
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_lo_bound,
  input logic          wr_hi_bound,
  input logic          wr_ptr,
  input logic [AW-1:0] wr_data,
  input logic [AW-1:0] step,
  input logic [1:0]    mode,
  input logic          upd,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] nxt_addr,
  input logic [AW-1:0] win_lo,
  input logic [AW-1:0] win_hi,
  input logic [AW-1:0] win_len
);
  logic [AW-1:0] step_mag;
  logic          step_fits;
  logic          ptr_inside;
  logic          quiet;

  assign step_mag   = step[AW-1] ? (~step + 1'b1) : step;
  assign step_fits  = (win_len == '0) || (step_mag <= win_len);
  assign ptr_inside = (cur_addr >= win_lo) && (cur_addr <= win_hi);
  assign quiet      = !wr_ptr && !wr_lo_bound && !wr_hi_bound;

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> cur_addr == $past(wr_data));

  assert_bound_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_bound || wr_hi_bound) && !wr_ptr && !upd |=> $stable(cur_addr));

  assert_linear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !wr_ptr && mode == 2'b00 |=>
      cur_addr == AW'($past(cur_addr) + $past(step)));

  assert_stay_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && quiet && mode == 2'b01 && ptr_inside && step_fits |=> ptr_inside);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd || mode == 2'b11) && !wr_ptr |=> $stable(cur_addr));

  assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !wr_ptr |=> cur_addr == $past(nxt_addr));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_lo_bound (wr_lo_bound),
  .wr_hi_bound (wr_hi_bound),
  .wr_ptr      (wr_ptr),
  .wr_data     (wr_data),
  .step        (step),
  .mode        (mode),
  .upd         (upd),
  .cur_addr    (cur_addr),
  .nxt_addr    (nxt_addr),
  .win_lo      (win_lo),
  .win_hi      (win_hi),
  .win_len     (win_len)
);

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;
  localparam int AW = 16;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_lo_bound = 1'b0;
  logic          wr_hi_bound = 1'b0;
  logic          wr_ptr = 1'b0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] step = '0;
  logic [1:0]    mode = 2'b00;
  logic          upd = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] nxt_addr;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  int exp_ptr = 0;
  int exp_a = 0;
  int exp_b = 0;

  circ_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_lo_bound(wr_lo_bound), .wr_hi_bound(wr_hi_bound),
    .wr_ptr(wr_ptr), .wr_data(wr_data), .step(step), .mode(mode), .upd(upd),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Reference: integer arithmetic restating the requirements.
  function automatic int ref_next(input int p, input int s, input int m);
    int sv;
    int lo;
    int hi;
    int len;
    int v;
    int c;
    int r;
    sv = (s >= 32768) ? s - 65536 : s;
    case (m)
      0: return (p + sv) & 16'hFFFF;
      1: begin
        lo  = (exp_a < exp_b) ? exp_a : exp_b;
        hi  = (exp_a < exp_b) ? exp_b : exp_a;
        len = hi - lo + 1;
        v   = p + sv;
        if (v > hi) v = v - len;
        else if (v < lo) v = v + len;
        return v & 16'hFFFF;
      end
      2: begin
        c = 0;
        r = 0;
        for (int i = AW - 1; i >= 0; i--) begin
          v = ((p >> i) & 1) + ((s >> i) & 1) + c;
          r = r | ((v & 1) << i);
          c = v >> 1;
        end
        return r;
      end
      default: return p;
    endcase
  endfunction

  task automatic write_reg(input int which, input int val);
    @(negedge clk);
    wr_data     = AW'(val);
    wr_lo_bound = (which == 0);
    wr_hi_bound = (which == 1);
    wr_ptr      = (which == 2);
    @(negedge clk);
    wr_lo_bound = 1'b0;
    wr_hi_bound = 1'b0;
    wr_ptr      = 1'b0;
    if (which == 0) exp_a = val;
    if (which == 1) exp_b = val;
    if (which == 2) exp_ptr = val;
  endtask

  task automatic do_step(input string tag, input int m, input int s, input int want);
    int e;
    @(negedge clk);
    mode = 2'(m);
    step = AW'(s);
    upd  = 1'b1;
    #1;
    e = ref_next(exp_ptr, s, m);
    check({tag, " model"}, e, want);
    check({tag, " nxt_addr R10"}, int'(nxt_addr), e);
    @(negedge clk);
    upd = 1'b0;
    exp_ptr = e;
    check(tag, int'(cur_addr), e);
  endtask

  task automatic t_reset();
    check("R1 cur_addr after reset", int'(cur_addr), 0);
    mode = 2'b00; step = '0;
    #1;
    check("R1 nxt_addr after reset", int'(nxt_addr), 0);
  endtask

  task automatic t_linear();
    write_reg(2, 16'h0400);
    check("R2 pointer load", int'(cur_addr), 16'h0400);
    do_step("R4 step 0x40", 0, 16'h0040, 16'h0440);
    write_reg(2, 16'h0400);
    do_step("R4 step 1", 0, 1, 16'h0401);
    write_reg(2, 0);
    do_step("R12 negative step", 0, 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_circ_fwd();
    write_reg(0, 16'h0200);
    write_reg(1, 16'h020F);
    write_reg(2, 16'h020E);
    do_step("R5 past upper edge", 1, 4, 16'h0202);
    do_step("R5 inside window", 1, 3, 16'h0205);
    write_reg(2, 16'h0200);
    do_step("R6 under lower edge", 1, 16'hFFFC, 16'h020C);
    write_reg(2, 16'h020F);
    do_step("R11 oversized step", 1, 16'h0025, 16'h0224);
  endtask

  task automatic t_circ_rev();
    write_reg(0, 16'h030F);
    write_reg(1, 16'h0300);
    write_reg(2, 16'h030E);
    do_step("R7 reversed past upper", 1, 4, 16'h0302);
    do_step("R7 reversed under lower", 1, 16'hFFFB, 16'h030D);
  endtask

  task automatic t_bounds_write();
    write_reg(2, 16'h1234);
    write_reg(0, 16'h0010);
    check("R3 first bound write", int'(cur_addr), 16'h1234);
    write_reg(1, 16'h0020);
    check("R3 second bound write", int'(cur_addr), 16'h1234);
  endtask

  task automatic t_bitrev();
    int seq[16] = '{0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 15};
    write_reg(2, 0);
    for (int k = 1; k < 16; k++) do_step("R8 bit-reversed walk", 2, 8, seq[k]);
    do_step("R8 carry dropped at bit 0", 2, 8, 0);
  endtask

  task automatic t_hold();
    write_reg(2, 16'h0055);
    do_step("R9 hold mode", 3, 16'h0007, 16'h0055);
    @(negedge clk);
    mode = 2'b00; step = 16'h0005; upd = 1'b0;
    @(negedge clk);
    check("R9 no strobe", int'(cur_addr), 16'h0055);
  endtask

  task automatic t_priority();
    @(negedge clk);
    mode = 2'b00; step = 16'h0001; upd = 1'b1;
    wr_ptr = 1'b1; wr_data = 16'h0ABC;
    @(negedge clk);
    upd = 1'b0; wr_ptr = 1'b0;
    exp_ptr = 16'h0ABC;
    check("R2 load beats update", int'(cur_addr), 16'h0ABC);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_circ_fwd();
    t_circ_rev();
    t_bounds_write();
    t_bitrev();
    t_hold();
    t_priority();
    done = 1'b1;
    report();
  end
endmodule